// File: doc/BRIEF.md
# Memory Bit Manipulation Unit

This unit carries out the bit-oriented read-modify-write and branch-test instructions of an 8-bit processor core. It covers two groups of instructions. The first group tests and then sets or resets accumulator-selected bits. The second group works on one bit of a zero-page byte: it can clear the bit, set the bit, or branch on the bit's value. The core issues an instruction by pulsing `start` with the opcode and the current accumulator. The unit then requests the operand byte for one cycle, spends one cycle computing, and either presents the byte to write back together with a Z flag update, or reports whether the branch is taken.

The unit does not generate addresses, does not drive the memory bus and does not compute branch targets. `rd_req` marks the cycle in which the core must present the operand on `mem_rdata`. `wr_en` marks the cycle in which `wr_data` is to be stored. `br_valid` marks the cycle in which `br_taken` is meaningful. The unit ignores any opcode outside its six classes.

Top module: `membit_unit`

## Requirements
- R1: For the single-bit forms, the bit number is opcode bits 6:4. Clear-bit opcodes are $07+16·n and set-bit opcodes are $87+16·n, where n is 0..7. Both forms address zero page only.
- R2: A clear-bit instruction writes back the operand with bit n forced to 0. All other bits are unchanged.
- R3: A set-bit instruction writes back the operand with bit n forced to 1. All other bits are unchanged.
- R4: The accumulator-reset instruction (opcodes $14 and $1C) writes back operand AND NOT accumulator.
- R5: The accumulator-set instruction (opcodes $04 and $0C) writes back operand OR accumulator.
- R6: For R4 and R5, `z_we` is asserted in the write cycle. `z_val` is 1 exactly when accumulator AND the unmodified operand equals zero.
- R7: Branch-on-clear opcodes are $0F+16·n and branch-on-set opcodes are $8F+16·n. They never write. In the modify cycle, `br_valid` is 1 and `br_taken` is 1 when bit n of the operand is 0 (branch-on-clear) or 1 (branch-on-set).
- R8: The single-bit forms (R2, R3, R7) never assert `z_we`.
- R9: An accepted instruction puts the unit in the read phase in the cycle after `start`, with `rd_req` high, and `mem_rdata` is sampled in that cycle. The modify phase follows. For write forms, the write phase comes next with `wr_en` high only there. `busy` is high across all phases. `wr_data`, `z_val` and `br_taken` are 0 whenever their enable is low.
- R10: `start` with any opcode outside the six classes leaves the unit idle. In that case there is no read, no write, no flag update and no branch report.
- R11: `start` while `busy` is high is ignored.
- R12: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Issue pulse, sampled when idle |
| opcode | input | 8 | Instruction opcode, sampled with start |
| acc | input | 8 | Accumulator value, sampled with start |
| mem_rdata | input | 8 | Operand byte, sampled in the read phase |
| busy | output | 1 | Instruction in progress |
| rd_req | output | 1 | Read phase: operand expected on mem_rdata |
| wr_en | output | 1 | Write phase: store wr_data |
| wr_data | output | 8 | Modified byte |
| z_we | output | 1 | Update the Z flag with z_val |
| z_val | output | 1 | New Z flag value |
| br_valid | output | 1 | Branch test result is valid |
| br_taken | output | 1 | Branch condition met |

## Verification
The assertions assume that `mem_rdata` holds the operand during the read phase, and that the core keeps `start` low or tolerates it being ignored while `busy` is high. The stimulus never relies on the operand outside that phase. Instead it drives random garbage on `mem_rdata` in every other cycle, and often holds `start` high with a different opcode while an instruction is in flight. It mixes opcodes of all six classes with unsupported ones. The cycle model in the bench therefore exercises the ignore rules as well as the data paths.

// File: rtl/membit_pkg.sv
// Package: shared types and opcode constants for the memory bit manipulation unit.
// Assumes an 8-bit opcode in which the single-bit forms carry their bit number in bits 6:4.
package membit_pkg;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_TRB  = 3'd1,
        OP_TSB  = 3'd2,
        OP_RMB  = 3'd3,
        OP_SMB  = 3'd4,
        OP_BBR  = 3'd5,
        OP_BBS  = 3'd6
    } op_class_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_MOD   = 2'd2,
        ST_WRITE = 2'd3
    } seq_state_e;

    localparam logic [7:0] OPC_ASET_ZP  = 8'h04;
    localparam logic [7:0] OPC_ASET_ABS = 8'h0C;
    localparam logic [7:0] OPC_ARST_ZP  = 8'h14;
    localparam logic [7:0] OPC_ARST_ABS = 8'h1C;
    localparam logic [3:0] LO_BITMEM    = 4'h7;
    localparam logic [3:0] LO_BITBR     = 4'hF;
    localparam int         IDX_LSB      = 4;

endpackage

// File: rtl/membit_decode.sv
// Module: membit_decode
// Classifies an opcode into one of the six supported classes and extracts
// the bit number used by the single-bit forms.
// Assumes IDX_W bits starting at opcode bit 4 hold the bit number (3 for bytes).
module membit_decode
    import membit_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic [7:0]       opcode,
    output op_class_e        cls,
    output logic [IDX_W-1:0] bit_idx,
    output logic             valid,
    output logic             is_branch
);

    // Class selection from the full opcode and its low nibble.
    always_comb begin
        cls = OP_NONE;
        if (opcode == OPC_ASET_ZP || opcode == OPC_ASET_ABS) begin
            cls = OP_TSB;
        end else if (opcode == OPC_ARST_ZP || opcode == OPC_ARST_ABS) begin
            cls = OP_TRB;
        end else if (opcode[3:0] == LO_BITMEM) begin
            cls = opcode[7] ? OP_SMB : OP_RMB;
        end else if (opcode[3:0] == LO_BITBR) begin
            cls = opcode[7] ? OP_BBS : OP_BBR;
        end
    end

    // Bit number field and derived class flags.
    always_comb begin
        bit_idx   = opcode[IDX_LSB +: IDX_W];
        valid     = (cls != OP_NONE);
        is_branch = (cls == OP_BBR) || (cls == OP_BBS);
    end

endmodule

// File: rtl/membit_alu.sv
// Module: membit_alu
// Combinational datapath: builds the one-hot bit mask, computes the modified
// byte for each class, the Z value from the unmodified operand, and the tested bit.
// Assumes cls, bit_idx, acc and operand are held stable by the caller.
module membit_alu
    import membit_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_class_e         cls,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] result,
    output logic              z_flag,
    output logic              bit_val
);

    logic [DATA_W-1:0] mask;

    // One comparator per bit position forms the single-bit mask.
    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign mask[g] = (bit_idx == IDX_W'(g));
    end

    // Modified byte per class.
    always_comb begin
        unique case (cls)
            OP_TRB:  result = operand & ~acc;
            OP_TSB:  result = operand | acc;
            OP_RMB:  result = operand & ~mask;
            OP_SMB:  result = operand | mask;
            default: result = operand;
        endcase
    end

    // Z from the pre-modify AND, and the selected bit for branch tests.
    always_comb begin
        z_flag  = ((acc & operand) == '0);
        bit_val = |(operand & mask);
    end

    // R2: a clear-bit result never holds the selected bit.
    assert_rmb_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == OP_RMB) |-> !result[bit_idx]);

    // R3: a set-bit result always holds the selected bit.
    assert_smb_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == OP_SMB) |-> result[bit_idx]);

    // R4: accumulator-reset leaves no accumulator bit set in the result.
    assert_trb_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == OP_TRB) |-> ((result & acc) == '0));

endmodule

// File: rtl/membit_seq.sv
// Module: membit_seq
// Phase sequencer: idle, read operand, modify, write. Branch tests return to
// idle after the modify phase. Issues capture strobes for the datapath registers.
// Assumes valid and is_branch are stable in the cycles they are consulted.
module membit_seq
    import membit_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       dec_valid,
    input  logic       op_branch,
    output seq_state_e state,
    output logic       cap_op,
    output logic       cap_mem,
    output logic       cap_res
);

    seq_state_e state_q, state_d;

    // Next phase selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start && dec_valid) state_d = ST_READ;
            ST_READ:  state_d = ST_MOD;
            ST_MOD:   state_d = op_branch ? ST_IDLE : ST_WRITE;
            ST_WRITE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Phase register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture strobes for the datapath registers.
    always_comb begin
        state   = state_q;
        cap_op  = (state_q == ST_IDLE) && start && dec_valid;
        cap_mem = (state_q == ST_READ);
        cap_res = (state_q == ST_MOD);
    end

    // R9: the write phase lasts one cycle and is followed by idle.
    assert_write_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE) |=> (state_q == ST_IDLE));

    // R9: a read phase is always followed by a modify phase.
    assert_read_then_mod_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ) |=> (state_q == ST_MOD));

endmodule

// File: rtl/membit_unit.sv
// Module: membit_unit (top)
// Executes the accumulator set/reset and single-bit clear/set/branch-test
// instructions. Latches opcode class, bit number and accumulator at issue,
// captures the operand in the read phase, registers the result in the modify
// phase and presents it in the write phase.
// Assumes the core supplies the operand on mem_rdata while rd_req is high.
module membit_unit
    import membit_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              rd_req,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              z_we,
    output logic              z_val,
    output logic              br_valid,
    output logic              br_taken
);

    localparam int IDX_W = $clog2(DATA_W);

    op_class_e         dec_cls;
    logic [IDX_W-1:0]  dec_idx;
    logic              dec_valid;
    logic              dec_branch;

    op_class_e         cls_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] mem_q;
    logic [DATA_W-1:0] res_q;
    logic              z_q;
    logic              branch_q;

    logic [DATA_W-1:0] alu_res;
    logic              alu_z;
    logic              alu_bit;

    seq_state_e        state;
    logic              cap_op, cap_mem, cap_res;

    membit_decode #(.IDX_W(IDX_W)) u_dec (
        .opcode    (opcode),
        .cls       (dec_cls),
        .bit_idx   (dec_idx),
        .valid     (dec_valid),
        .is_branch (dec_branch)
    );

    membit_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dec_valid (dec_valid),
        .op_branch (branch_q),
        .state     (state),
        .cap_op    (cap_op),
        .cap_mem   (cap_mem),
        .cap_res   (cap_res)
    );

    membit_alu #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_alu (
        .clk     (clk),
        .rst_n   (rst_n),
        .cls     (cls_q),
        .bit_idx (idx_q),
        .acc     (acc_q),
        .operand (mem_q),
        .result  (alu_res),
        .z_flag  (alu_z),
        .bit_val (alu_bit)
    );

    // Issue latch: class, bit number and accumulator of the accepted instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q    <= OP_NONE;
            idx_q    <= '0;
            acc_q    <= '0;
            branch_q <= 1'b0;
        end else if (cap_op) begin
            cls_q    <= dec_cls;
            idx_q    <= dec_idx;
            acc_q    <= acc;
            branch_q <= dec_branch;
        end
    end

    // Operand capture during the read phase.
    always_ff @(posedge clk) begin
        if (!rst_n)       mem_q <= '0;
        else if (cap_mem) mem_q <= mem_rdata;
    end

    // Result and Z capture during the modify phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            z_q   <= 1'b0;
        end else if (cap_res) begin
            res_q <= alu_res;
            z_q   <= alu_z;
        end
    end

    // Output strobes and gated data.
    always_comb begin
        busy     = (state != ST_IDLE);
        rd_req   = (state == ST_READ);
        wr_en    = (state == ST_WRITE);
        wr_data  = wr_en ? res_q : '0;
        z_we     = wr_en && ((cls_q == OP_TRB) || (cls_q == OP_TSB));
        z_val    = z_we && z_q;
        br_valid = (state == ST_MOD) && branch_q;
        br_taken = br_valid && ((cls_q == OP_BBS) ? alu_bit : !alu_bit);
    end

    // R6: a Z update only ever accompanies a write.
    assert_z_with_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        z_we |-> wr_en);

    // R7: a branch report never coincides with a write or a flag update (R8).
    assert_branch_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |-> (!wr_en && !z_we));

    // R9: a write comes two cycles after the operand read.
    assert_write_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(rd_req, 2));

    // R10: an unsupported opcode at issue keeps the unit idle.
    assert_bad_opcode_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !dec_valid) |=> !busy);

    // R11: an issue while busy never re-enters the read phase directly.
    assert_busy_ignores_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rd_req) |=> !rd_req);

endmodule

// File: tb/sim_membit_unit.sv
// Bench: cycle-by-cycle behavioural model of the unit, compared on every clock.
module sim_membit_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] opcode = 8'h00;
    logic [7:0] acc = 8'h00;
    logic [7:0] mem_rdata = 8'h00;
    logic       busy, rd_req, wr_en, z_we, z_val, br_valid, br_taken;
    logic [7:0] wr_data;

    int vectors = 0;
    int errors = 0;
    bit done = 0;

    // Model state
    int       ph = 0;
    bit [7:0] m_op = 0, m_acc = 0, m_mem = 0;

    always #2.5 clk = ~clk;

    membit_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .acc(acc),
        .mem_rdata(mem_rdata), .busy(busy), .rd_req(rd_req), .wr_en(wr_en),
        .wr_data(wr_data), .z_we(z_we), .z_val(z_val), .br_valid(br_valid),
        .br_taken(br_taken)
    );

    // Class numbering: 0 none, 1 acc-reset, 2 acc-set, 3 clear-bit, 4 set-bit, 5 br-clear, 6 br-set
    function automatic int kind(input bit [7:0] op);
        if (op == 8'h04 || op == 8'h0C) return 2;
        if (op == 8'h14 || op == 8'h1C) return 1;
        if (op[3:0] == 4'h7) return op[7] ? 4 : 3;
        if (op[3:0] == 4'hF) return op[7] ? 6 : 5;
        return 0;
    endfunction

    function automatic bit [7:0] ref_result(input bit [7:0] op, input bit [7:0] a, input bit [7:0] m);
        bit [7:0] r;
        int n;
        r = m;
        n = int'(op[6:4]);
        case (kind(op))
            1: r = m & ~a;
            2: r = m | a;
            3: r[n] = 1'b0;
            4: r[n] = 1'b1;
            default: r = m;
        endcase
        return r;
    endfunction

    function automatic string data_tag(input bit [7:0] op);
        case (kind(op))
            1: return "R4";
            2: return "R5";
            3: return "R1/R2";
            4: return "R1/R3";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string what, input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare(input string tag_all);
        int  k;
        bit  e_wr, e_zwe, e_brv, e_brt;
        bit [7:0] e_data;
        k      = kind(m_op);
        e_wr   = (ph == 3);
        e_data = e_wr ? ref_result(m_op, m_acc, m_mem) : 8'h00;
        e_zwe  = e_wr && (k == 1 || k == 2);
        e_brv  = (ph == 2) && (k == 5 || k == 6);
        e_brt  = e_brv && ((k == 6) ? m_mem[m_op[6:4]] : !m_mem[m_op[6:4]]);
        check("busy",     tag_all.len() ? tag_all : "R9/R10/R11", int'(busy), int'(ph != 0));
        check("rd_req",   tag_all.len() ? tag_all : "R9/R10/R11", int'(rd_req), int'(ph == 1));
        check("wr_en",    tag_all.len() ? tag_all : "R7/R9", int'(wr_en), int'(e_wr));
        check("wr_data",  tag_all.len() ? tag_all : data_tag(m_op), int'(wr_data), int'(e_data));
        check("z_we",     tag_all.len() ? tag_all : "R6/R8", int'(z_we), int'(e_zwe));
        check("z_val",    tag_all.len() ? tag_all : "R6", int'(z_val),
              int'(e_zwe && ((m_acc & m_mem) == 8'h00)));
        check("br_valid", tag_all.len() ? tag_all : "R7", int'(br_valid), int'(e_brv));
        check("br_taken", tag_all.len() ? tag_all : "R7", int'(br_taken), int'(e_brt));
    endtask

    // Model advance from the inputs about to be sampled at the next edge.
    task automatic advance();
        if (!rst_n) begin
            ph = 0;
            return;
        end
        case (ph)
            0: if (start && kind(opcode) != 0) begin ph = 1; m_op = opcode; m_acc = acc; end
            1: begin ph = 2; m_mem = mem_rdata; end
            2: ph = (kind(m_op) >= 5) ? 0 : 3;
            default: ph = 0;
        endcase
    endtask

    task automatic cycle(input bit s, input bit [7:0] op, input bit [7:0] a, input bit [7:0] m);
        start = s; opcode = op; acc = a; mem_rdata = m;
        advance();
        @(negedge clk);
        compare("");
    endtask

    // Issue one instruction; optionally hold start with another opcode while busy (R11).
    task automatic issue(input bit [7:0] op, input bit [7:0] a, input bit [7:0] m,
                         input bit hold, input bit [7:0] op2);
        cycle(1'b1, op, a, 8'($urandom));
        cycle(hold, op2, 8'($urandom), m);
        cycle(hold, op2, 8'($urandom), 8'($urandom));
        cycle(1'b0, 8'($urandom), 8'($urandom), 8'($urandom));
    endtask

    initial begin
        // Reset with active inputs: outputs must stay at 0 (R12).
        start = 1'b1; opcode = 8'h87; acc = 8'hFF; mem_rdata = 8'hA5;
        repeat (3) @(negedge clk);
        advance();
        compare("R12");
        rst_n = 1'b1;
        cycle(1'b0, 8'h00, 8'h00, 8'h00);

        // Clear-bit and set-bit forms, every bit (R1, R2, R3, R8).
        for (int n = 0; n < 8; n++) begin
            issue(8'h07 + 8'(16 * n), 8'h00, 8'hFF, 1'b0, 8'h00);
            issue(8'h87 + 8'(16 * n), 8'hFF, 8'h00, 1'b0, 8'h00);
            issue(8'h07 + 8'(16 * n), 8'h5A, 8'h3C, 1'b1, 8'h04);
        end
        // Accumulator forms: zero result, overlap, disjoint, zero accumulator (R4, R5, R6).
        issue(8'h04, 8'h0F, 8'hF0, 1'b0, 8'h00);
        issue(8'h0C, 8'h3C, 8'h18, 1'b0, 8'h00);
        issue(8'h14, 8'hFF, 8'hFF, 1'b0, 8'h00);
        issue(8'h1C, 8'h00, 8'hA5, 1'b0, 8'h00);
        issue(8'h14, 8'h81, 8'h7E, 1'b1, 8'h87);
        // Branch tests, both polarities per bit (R7, R8).
        for (int n = 0; n < 8; n++) begin
            issue(8'h0F + 8'(16 * n), 8'h00, 8'(1 << n), 1'b0, 8'h00);
            issue(8'h0F + 8'(16 * n), 8'h00, ~8'(1 << n), 1'b0, 8'h00);
            issue(8'h8F + 8'(16 * n), 8'h00, 8'(1 << n), 1'b1, 8'h14);
            issue(8'h8F + 8'(16 * n), 8'h00, ~8'(1 << n), 1'b0, 8'h00);
        end
        // Unsupported opcodes stay idle (R10).
        issue(8'hEA, 8'hFF, 8'hFF, 1'b0, 8'h00);
        issue(8'hA9, 8'hFF, 8'h00, 1'b0, 8'h00);
        issue(8'h05, 8'h12, 8'h34, 1'b0, 8'h00);
        issue(8'h1D, 8'h12, 8'h34, 1'b1, 8'h0D);
        // Random traffic mixing all classes and held start.
        for (int i = 0; i < 4000; i++) begin
            bit [7:0] op;
            op = 8'($urandom);
            if ($urandom_range(0, 1) == 0) op[3:0] = ($urandom_range(0, 1) == 0) ? 4'h7 : 4'hF;
            cycle(($urandom_range(0, 3) != 0), op, 8'($urandom), 8'($urandom));
        end
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule